// File: doc/BRIEF.md
# Indexed-Access Interrupt Controller

This block collects a parameterized number of level-sensitive interrupt lines and presents them to a single CPU as one request signal. Software controls it over a simple 32-bit register bus that has two banks: a global bank and a per-CPU bank. Software never edits a bitmap. To enable, disable, mask or unmask a source, it writes that source's number to a dedicated register.

A source can be delivered only while three things hold: its line is high, it is enabled and it is unmasked. A read of the acknowledge register returns the lowest-numbered deliverable source, or 1023 when none is deliverable. The interrupt handler reads that register repeatedly until it sees 1023. The global control word reports how many sources are implemented, so software can size its tables.

Top module: `idx_irq_ctrl`

## Requirements
- R1: After reset every source is disabled and masked, `cpu_irq` is 0, and the acknowledge read returns 1023.
- R2: A write to global-bank offset 0x30 sets the enable bit of the source numbered by `bus_wdata[9:0]`. The upper data bits are ignored.
- R3: A write to global-bank offset 0x34 clears the enable bit of the source numbered by `bus_wdata[9:0]`.
- R4: A write to per-CPU-bank offset 0x48 masks the numbered source, and a write to per-CPU-bank offset 0x4C unmasks it.
- R5: A read of global-bank offset 0x00 returns `NUM_SRC` in bits [11:2] and zero in all other bits. Every read returns its data on `bus_rdata` one clock after the cycle in which `bus_rd` is high.
- R6: A read of per-CPU-bank offset 0x44 returns, in bits [9:0], the lowest-numbered source whose line is high, enabled and unmasked. Bits [31:10] are zero. The value is 1023 when no source qualifies, and it reflects the state in the cycle of the read.
- R7: `cpu_irq` is high in the cycle after any source is deliverable, and low in the cycle after none is.
- R8: Sources are level-sensitive. When a line falls, that source stops being reported at once, with no latched pending state.
- R9: A set, clear, mask or unmask write whose number is `NUM_SRC` or above changes no state.
- R10: A read of any other offset, or of a valid offset in the wrong bank, returns zero. A write to such an address changes no state. Bank select is `bus_bank` = 0 for global and 1 for per-CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_bank | input | 1 | Bank select: 0 global, 1 per-CPU |
| bus_addr | input | 8 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | NUM_SRC | Level interrupt inputs |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The assertions check on every cycle that each set, clear, mask and unmask write takes effect on the named source, and that out-of-range numbers leave all state unchanged. They also check that the arbiter's choice is deliverable and has no deliverable source below it, and that `cpu_irq` follows the arbiter one clock later. Other behaviours can only be shown by the bench's scenarios. These are:
- the exact bus encoding, including bank and offset aliasing and the zero returned for unmapped reads;
- the control word layout;
- the drain sequence a handler performs as lines fall one by one.

// File: rtl/idx_irq_pkg.sv
`timescale 1ns/1ps
package idx_irq_pkg;
  localparam int IDXW = 10;
  localparam logic [IDXW-1:0] NO_SRC = 10'd1023;

  // global bank offsets
  localparam logic [7:0] G_CTRL   = 8'h00;
  localparam logic [7:0] G_EN_SET = 8'h30;
  localparam logic [7:0] G_EN_CLR = 8'h34;
  // per-CPU bank offsets
  localparam logic [7:0] C_ACK    = 8'h44;
  localparam logic [7:0] C_MSK_SET = 8'h48;
  localparam logic [7:0] C_MSK_CLR = 8'h4C;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic msk_set;
    logic msk_clr;
    logic rd_ctrl;
    logic rd_ack;
  } strobe_t;
endpackage

// File: rtl/idx_irq_decode.sv
`timescale 1ns/1ps
module idx_irq_decode
  import idx_irq_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_bank,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output strobe_t         stb,
  output logic [IDXW-1:0] wr_idx
);
  logic idx_ok;
  logic g_sel, c_sel;

  assign wr_idx = bus_wdata[IDXW-1:0];
  assign idx_ok = (wr_idx < IDXW'(NUM_SRC));
  assign g_sel  = !bus_bank;
  assign c_sel  = bus_bank;

  always_comb begin
    stb = '0;
    stb.en_set  = bus_wr && idx_ok && g_sel && (bus_addr == G_EN_SET);
    stb.en_clr  = bus_wr && idx_ok && g_sel && (bus_addr == G_EN_CLR);
    stb.msk_set = bus_wr && idx_ok && c_sel && (bus_addr == C_MSK_SET);
    stb.msk_clr = bus_wr && idx_ok && c_sel && (bus_addr == C_MSK_CLR);
    stb.rd_ctrl = bus_rd && g_sel && (bus_addr == G_CTRL);
    stb.rd_ack  = bus_rd && c_sel && (bus_addr == C_ACK);
  end
endmodule

// File: rtl/idx_irq_state.sv
`timescale 1ns/1ps
module idx_irq_state
  import idx_irq_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [NUM_SRC-1:0] irq_lines,
  output logic [NUM_SRC-1:0] deliv
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] msk_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i]  <= 1'b0;
        msk_q[i] <= 1'b1;
      end else begin
        if (stb.en_set && wr_idx == IDXW'(i))  en_q[i] <= 1'b1;
        if (stb.en_clr && wr_idx == IDXW'(i))  en_q[i] <= 1'b0;
        if (stb.msk_set && wr_idx == IDXW'(i)) msk_q[i] <= 1'b1;
        if (stb.msk_clr && wr_idx == IDXW'(i)) msk_q[i] <= 1'b0;
      end
    end

    p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
      (stb.en_set && wr_idx == IDXW'(i)) |=> en_q[i]);
    p_en_clr_r3: assert property (@(posedge clk) disable iff (rst)
      (stb.en_clr && wr_idx == IDXW'(i)) |=> !en_q[i]);
    p_mask_r4: assert property (@(posedge clk) disable iff (rst)
      (stb.msk_set && wr_idx == IDXW'(i)) |=> msk_q[i]);
    p_unmask_r4: assert property (@(posedge clk) disable iff (rst)
      (stb.msk_clr && wr_idx == IDXW'(i)) |=> !msk_q[i]);
  end

  assign deliv = irq_lines & en_q & ~msk_q;

  // out-of-range index leaves state untouched
  p_range_r9: assert property (@(posedge clk) disable iff (rst)
    (!stb.en_set && !stb.en_clr && !stb.msk_set && !stb.msk_clr)
      |=> ($stable(en_q) && $stable(msk_q)));
endmodule

// File: rtl/idx_irq_arb.sv
`timescale 1ns/1ps
module idx_irq_arb
  import idx_irq_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] deliv,
  output logic [IDXW-1:0]    ack_idx,
  output logic               ack_valid
);
  always_comb begin
    ack_idx   = NO_SRC;
    ack_valid = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (deliv[i]) begin
        ack_idx   = IDXW'(i);
        ack_valid = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    if (i == 0) begin : g_first
      p_lowest_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_idx == IDXW'(i)) |-> deliv[i]);
    end else begin : g_rest
      p_lowest_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_idx == IDXW'(i)) |-> (deliv[i] && !(|deliv[i-1:0])));
    end
  end

  p_none_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_idx == NO_SRC) |-> (deliv == '0));
endmodule

// File: rtl/idx_irq_ctrl.sv
`timescale 1ns/1ps
module idx_irq_ctrl
  import idx_irq_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_bank,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_lines,
  output logic               cpu_irq
);
  localparam logic [31:0] CTRL_WORD = {20'd0, IDXW'(NUM_SRC), 2'b00};

  strobe_t            stb;
  logic [IDXW-1:0]    wr_idx;
  logic [NUM_SRC-1:0] deliv;
  logic [IDXW-1:0]    ack_idx;
  logic               ack_valid;

  idx_irq_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_bank(bus_bank),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .stb(stb), .wr_idx(wr_idx)
  );

  idx_irq_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk(clk), .rst(rst), .stb(stb), .wr_idx(wr_idx),
    .irq_lines(irq_lines), .deliv(deliv)
  );

  idx_irq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst(rst), .deliv(deliv),
    .ack_idx(ack_idx), .ack_valid(ack_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      cpu_irq <= ack_valid;
      if (bus_rd) begin
        if (stb.rd_ctrl)     bus_rdata <= CTRL_WORD;
        else if (stb.rd_ack) bus_rdata <= {22'd0, ack_idx};
        else                 bus_rdata <= '0;
      end
    end
  end

  p_irq_up_r7: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> cpu_irq);
  p_irq_down_r7: assert property (@(posedge clk) disable iff (rst)
    !ack_valid |=> !cpu_irq);
endmodule

// File: tb/test_idx_irq_ctrl.sv
`timescale 1ns/1ps
module test_idx_irq_ctrl;
  localparam int N = 40;

  logic clk = 1'b0;
  logic rst;
  logic bus_wr, bus_rd, bus_bank;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] irq_lines;
  logic cpu_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  idx_irq_ctrl #(.NUM_SRC(N)) i_idx_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_bank(bus_bank), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_lines(irq_lines), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // all drives happen just after a falling edge
  task automatic wr(input logic bank, input logic [7:0] addr, input logic [31:0] d);
    bus_wr = 1'b1; bus_bank = bank; bus_addr = addr; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic bank, input logic [7:0] addr, output logic [31:0] d);
    bus_rd = 1'b1; bus_bank = bank; bus_addr = addr;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack(output logic [31:0] d);
    rd(1'b1, 8'h44, d);
  endtask

  task automatic enable_src(input int s);
    wr(1'b0, 8'h30, 32'(s));
    wr(1'b1, 8'h4C, 32'(s));
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_bank = 0; bus_addr = 0;
    bus_wdata = 0; irq_lines = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    irq_lines = '1;
    @(negedge clk);
    chk("R1 cpu_irq after reset with lines high", 32'(cpu_irq), 0);
    ack(d);
    chk("R1 ack after reset", d, 1023);
    irq_lines = '0;
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    rd(1'b0, 8'h00, d);
    chk("R5 control word", d, 32'(N) << 2);
  endtask

  task automatic t_enable_mask();
    logic [31:0] d;
    irq_lines[7] = 1'b1;
    wr(1'b0, 8'h30, 32'd7);
    ack(d);
    chk("R2/R4 enabled but masked not reported", d, 1023);
    wr(1'b1, 8'h4C, 32'd7);
    ack(d);
    chk("R4 unmask delivers", d, 7);
    chk("R7 cpu_irq high", 32'(cpu_irq), 1);
    wr(1'b1, 8'h48, 32'd7);
    ack(d);
    chk("R4 mask hides", d, 1023);
    @(negedge clk);
    chk("R7 cpu_irq low after mask", 32'(cpu_irq), 0);
    wr(1'b1, 8'h4C, 32'd7);
    wr(1'b0, 8'h34, 32'd7);
    ack(d);
    chk("R3 clear enable hides", d, 1023);
    wr(1'b0, 8'h30, 32'h0001_0007);
    ack(d);
    chk("R2 upper data bits ignored", d, 7);
    wr(1'b0, 8'h34, 32'd7);
    irq_lines[7] = 1'b0;
  endtask

  task automatic t_priority();
    logic [31:0] d;
    enable_src(3); enable_src(12); enable_src(N - 1);
    irq_lines[12] = 1'b1; irq_lines[N-1] = 1'b1;
    @(negedge clk);
    ack(d);
    chk("R6 lowest of 12 and top", d, 12);
    irq_lines[3] = 1'b1;
    ack(d);
    chk("R6 new lower source wins at once", d, 3);
    irq_lines[3] = 1'b0;
    ack(d);
    chk("R8 level drop removes source", d, 12);
    irq_lines[12] = 1'b0;
    ack(d);
    chk("R6 highest index source", d, N - 1);
    irq_lines[N-1] = 1'b0;
    ack(d);
    chk("R6 drain ends at 1023", d, 1023);
    @(negedge clk);
    chk("R7 cpu_irq low when drained", 32'(cpu_irq), 0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    irq_lines[5] = 1'b1;
    enable_src(5);
    wr(1'b0, 8'h34, 32'(N));
    wr(1'b0, 8'h34, 32'd1023);
    wr(1'b1, 8'h48, 32'(N + 5));
    wr(1'b1, 8'h48, 32'd1023);
    ack(d);
    chk("R9 out-of-range writes ignored", d, 5);
    wr(1'b0, 8'h48, 32'd5);
    wr(1'b1, 8'h34, 32'd5);
    wr(1'b0, 8'h3C, 32'd5);
    ack(d);
    chk("R10 writes in wrong bank ignored", d, 5);
    rd(1'b1, 8'h00, d);
    chk("R10 ctrl offset in per-CPU bank reads zero", d, 0);
    rd(1'b0, 8'h44, d);
    chk("R10 ack offset in global bank reads zero", d, 0);
    rd(1'b0, 8'h30, d);
    chk("R10 set register reads zero", d, 0);
    irq_lines[5] = 1'b0;
    ack(d);
    chk("R8 line low gives 1023", d, 1023);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_ctrl();
    t_enable_mask();
    t_priority();
    t_range();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule